// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a management-bus master for Ethernet PHYs. Software writes one 32-bit frame word into the frame register, and the block sends it on the two-wire management bus. It first sends a run of ones as a preamble and then the 32 frame bits, most significant bit first. The clock it produces on `mdc` comes from a divider field in the speed register. The data pin is split into `mdio_out`, `mdio_oe` and `mdio_in`, so that a pad cell outside the block can join them.

A frame word carries, from the top bit down: the start pattern (01), a two-bit opcode at bits 29:28, a five-bit PHY address, a five-bit register address, the two turnaround bits and sixteen data bits. When the opcode is 10 the frame is a read. The engine then releases the pin for the turnaround and the data bits, and it samples the 16 bits that the PHY returns into bits 15:0 of the frame register. When the frame ends, bit 0 of the event register is set. Software clears it by writing a one to that bit.

The sequencer has five states. IDLE moves to PREAMBLE when a frame write is accepted. PREAMBLE moves to HEADER after the last preamble bit. HEADER moves to TURN after 14 bits (start, opcode and both addresses). TURN moves to DATA after 2 bits. DATA returns to IDLE after 16 bits, and that return raises the completion event. Every move between bits happens on a falling edge of `mdc`.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the frame, speed and event registers read zero, and `mdc` and `mdio_oe` are low.
- R2: A frame-register write (address 0) accepted while idle sends PRE_LEN (32) ones and then the 32 frame bits MSB first. Bits change only on falling edges of `mdc` and are stable while `mdc` is high.
- R3: While a frame is in progress, `mdc` toggles every D clocks, where D is the divider, so its period is 2·D clocks. `mdc` rises only while a frame is in progress.
- R4: When frame bits 29:28 are 10 (read), `mdio_oe` is low for the 2 turnaround bits and the 16 data bits. `mdio_in` is sampled on each rising `mdc` edge of the data bits, MSB first, and at completion the samples replace bits 15:0 of the frame register.
- R5: For any other opcode (00, 01, 11), `mdio_oe` stays high for all 64 bits.
- R6: When the last bit ends, bit 0 of the event register (address 2) is set, and `mdc` and `mdio_oe` are low again.
- R7: Writing the event register with bit 0 set clears the done bit, and writing all ones clears it too. Writing it with bit 0 clear leaves the bit unchanged. A completion in the same cycle as a clear wins.
- R8: A frame-register write while a frame is in progress is ignored: the frame register and the bits on the bus are unchanged.
- R9: With a divider of 0, a frame-register write is dropped: `mdc` does not toggle, no event is raised and the frame register keeps its old value.
- R10: The speed register (address 1) holds the divider in bits DIV_W:1. Every other bit reads zero.
- R11: After a frame that is not a read, the frame register still reads the word that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 frame, 1 speed, 2 event |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data driven onto the pin |
| mdio_oe | output | 1 | Pin drive enable |
| mdio_in | input | 1 | Data sampled from the pin |

## Verification
The bench builds the block with DIV_W = 6 and PRE_LEN = 32. With these defaults every divider value it selects at run time is reachable, and it uses 1, 2 and 3: the single-clock half period, the even case and the odd case. It also reads back the full six-bit field. A behavioural PHY watches `mdc` and records every bit and drive-enable value. For reads it answers with chosen data patterns, including single bits at both ends of the word. The PHY's observations are compared against the frames the bench has queued, so an ignored mid-frame write, a frame dropped with a zero divider and an unknown opcode each show up as an extra, missing or altered frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_t;

    localparam logic [1:0] ADDR_FRAME = 2'd0;
    localparam logic [1:0] ADDR_SPEED = 2'd1;
    localparam logic [1:0] ADDR_EVENT = 2'd2;

    localparam int         EV_DONE_BIT = 0;
    localparam logic [1:0] OP_READ     = 2'b10;
    localparam int         OP_MSB      = 29;
    localparam int         OP_LSB      = 28;

    localparam int HDR_BITS = 14;
    localparam int TA_BITS  = 2;
    localparam int DAT_BITS = 16;

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_end;
    logic             active;

    assign active = run && (div != '0);
    assign at_end = active && (cnt_q == div - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!active) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (at_end) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign rise_p = at_end && !mdc;
    assign fall_p = at_end &&  mdc;

endmodule

// File: rtl/mdio_sequencer.sv
module mdio_sequencer
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] frame_word,
    input  logic        rise_p,
    input  logic        fall_p,
    input  logic        mdio_in,
    output logic        busy,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        done_p,
    output logic        is_read,
    output logic [15:0] rd_data
);

    localparam int MAXLEN = (PRE_LEN > DAT_BITS) ? PRE_LEN : DAT_BITS;
    localparam int CW     = $clog2(MAXLEN);

    mdio_state_t    state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [31:0]    sh_q;
    logic           rd_q;
    logic [15:0]    cap_q;
    logic           last_bit;

    always_comb begin
        last_bit = 1'b0;
        unique case (state_q)
            ST_IDLE:     last_bit = 1'b0;
            ST_PREAMBLE: last_bit = (cnt_q == CW'(PRE_LEN - 1));
            ST_HEADER:   last_bit = (cnt_q == CW'(HDR_BITS - 1));
            ST_TURN:     last_bit = (cnt_q == CW'(TA_BITS - 1));
            ST_DATA:     last_bit = (cnt_q == CW'(DAT_BITS - 1));
            default:     last_bit = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)             state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_p && last_bit) state_d = ST_HEADER;
            ST_HEADER:   if (fall_p && last_bit) state_d = ST_TURN;
            ST_TURN:     if (fall_p && last_bit) state_d = ST_DATA;
            ST_DATA:     if (fall_p && last_bit) state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
            rd_q  <= 1'b0;
            cap_q <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (start) begin
                    cnt_q <= '0;
                    sh_q  <= frame_word;
                    rd_q  <= (frame_word[OP_MSB:OP_LSB] == OP_READ);
                end
            end else begin
                if (fall_p) begin
                    if (last_bit) cnt_q <= '0;
                    else          cnt_q <= cnt_q + CW'(1);
                    if (state_q != ST_PREAMBLE) sh_q <= {sh_q[30:0], 1'b0};
                end
                if (rise_p && rd_q && state_q == ST_DATA)
                    cap_q <= {cap_q[14:0], mdio_in};
            end
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        done_p   = (state_q == ST_DATA) && fall_p && last_bit;
        is_read  = rd_q;
        rd_data  = cap_q;
        mdio_out = 1'b0;
        mdio_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin mdio_out = 1'b0;     mdio_oe = 1'b0;  end
            ST_PREAMBLE: begin mdio_out = 1'b1;     mdio_oe = 1'b1;  end
            ST_HEADER:   begin mdio_out = sh_q[31]; mdio_oe = 1'b1;  end
            ST_TURN,
            ST_DATA:     begin mdio_out = rd_q ? 1'b0 : sh_q[31]; mdio_oe = !rd_q; end
            default:     begin mdio_out = 1'b0;     mdio_oe = 1'b0;  end
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 6,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    input  logic        reg_write,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);

    localparam int SPD_PAD = 31 - DIV_W;

    logic [31:0]      frame_q;
    logic [DIV_W-1:0] div_q;
    logic             ev_done;
    logic             busy;
    logic             done_p;
    logic             is_read;
    logic [15:0]      rd_data;
    logic             rise_p;
    logic             fall_p;
    logic             wr_frame, wr_speed, wr_event, start;

    assign wr_frame = reg_valid && reg_write && (reg_addr == ADDR_FRAME);
    assign wr_speed = reg_valid && reg_write && (reg_addr == ADDR_SPEED);
    assign wr_event = reg_valid && reg_write && (reg_addr == ADDR_EVENT);
    assign start    = wr_frame && !busy && (div_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            div_q   <= '0;
            ev_done <= 1'b0;
        end else begin
            if (start)
                frame_q <= reg_wdata;
            else if (done_p && is_read)
                frame_q[15:0] <= rd_data;
            if (wr_speed)
                div_q <= reg_wdata[DIV_W:1];
            if (done_p)
                ev_done <= 1'b1;
            else if (wr_event && reg_wdata[EV_DONE_BIT])
                ev_done <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_FRAME: reg_rdata = frame_q;
            ADDR_SPEED: reg_rdata = {{SPD_PAD{1'b0}}, div_q, 1'b0};
            ADDR_EVENT: reg_rdata = {31'b0, ev_done};
            default:    reg_rdata = '0;
        endcase
    end

    mdc_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .div    (div_q),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_sequencer #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_word (reg_wdata),
        .rise_p     (rise_p),
        .fall_p     (fall_p),
        .mdio_in    (mdio_in),
        .busy       (busy),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .done_p     (done_p),
        .is_read    (is_read),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             done_p,
    input logic             ev_done,
    input logic [31:0]      frame_q,
    input logic [DIV_W-1:0] div_q,
    input logic             reg_valid,
    input logic             reg_write,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata
);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

    p_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    p_mdc_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    p_done_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> ev_done);

    p_clear_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == 2'd2 && reg_wdata[0] && !done_p)
        |=> !ev_done);

    p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_p) |=> $stable(frame_q));

    p_zero_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && div_q == '0) |=> !busy);

endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .done_p    (done_p),
    .ev_done   (ev_done),
    .frame_q   (frame_q),
    .div_q     (div_q),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;

    localparam int DIV_W = 6;
    localparam logic [1:0] A_FRAME = 2'd0, A_SPEED = 2'd1, A_EVENT = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int n_checks = 0, n_err = 0;
    int pushed = 0, seen = 0, total_rises = 0, mon_i = 0, cur_div = 1;
    bit finished = 0;
    logic [15:0] phy_word = '0;
    logic [63:0] q_bits[$];
    logic [63:0] q_oe[$];

    always #2 clk = ~clk;

    mdio_mgmt_master #(.DIV_W(DIV_W), .PRE_LEN(32)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic set_div(input int d);
        cur_div = d;
        reg_wr(A_SPEED, 32'(d) << 1);
    endtask

    task automatic start_txn(input logic [31:0] fw, input logic [15:0] rdw);
        bit rd;
        rd = (fw[29:28] == 2'b10);
        phy_word = rdw;
        q_bits.push_back({32'hFFFF_FFFF, fw});
        q_oe.push_back(rd ? ({64{1'b1}} << 18) : {64{1'b1}});
        pushed++;
        reg_wr(A_FRAME, fw);
    endtask

    task automatic finish_txn(input logic [31:0] fw, input logic [15:0] rdw);
        logic [31:0] v;
        bit got;
        bit rd;
        rd = (fw[29:28] == 2'b10);
        got = 0;
        for (int k = 0; k < 40000 && !got; k++) begin
            reg_rd(A_EVENT, v);
            got = v[0];
        end
        chk(got, "R6 done event set", 64'(got), 64'd1);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R6 bus quiet after frame", {mdc, mdio_oe}, 0);
        reg_rd(A_FRAME, v);
        if (rd) chk(v == {fw[31:16], rdw}, "R4 read data in frame", v, {fw[31:16], rdw});
        else    chk(v == fw, "R11 frame kept after write", v, fw);
    endtask

    // PHY-side monitor: records each bit at the rising MDC edge
    initial begin
        forever begin
            logic [63:0] ob, oo, eb, eo;
            realtime t0, t1;
            ob = '0; oo = '0; t0 = 0.0;
            for (int i = 0; i < 64; i++) begin
                @(posedge mdc);
                #1;
                mon_i = i + 1;
                total_rises++;
                ob[63-i] = mdio_out;
                oo[63-i] = mdio_oe;
                if (i == 1) t0 = $realtime;
                if (i == 2) begin
                    t1 = $realtime;
                    chk((t1 - t0) == 8.0 * cur_div, "R3 mdc period",
                        64'(longint'(t1 - t0)), 64'(8 * cur_div));
                end
            end
            mon_i = 0;
            seen++;
            if (q_bits.size() == 0) begin
                chk(0, "R2 unexpected frame on bus", ob, 0);
            end else begin
                eb = q_bits.pop_front();
                eo = q_oe.pop_front();
                chk((ob & eo) == (eb & eo), "R2 frame bits", ob & eo, eb & eo);
                chk(oo == eo, "R4/R5 drive enable pattern", oo, eo);
            end
        end
    end

    // PHY-side driver: changes read data after falling MDC
    initial begin
        forever begin
            @(negedge mdc);
            #1;
            if (mon_i >= 48 && mon_i < 64) mdio_in = phy_word[63 - mon_i];
            else                           mdio_in = 1'b1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++; n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int r0;
        repeat (3) @(posedge clk);
        #1 chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins in reset", {mdc, mdio_oe}, 0);
        @(negedge clk) rst_n = 1'b1;
        reg_rd(A_FRAME, v); chk(v == 0, "R1 frame reset", v, 0);
        reg_rd(A_SPEED, v); chk(v == 0, "R1 speed reset", v, 0);
        reg_rd(A_EVENT, v); chk(v == 0, "R1 event reset", v, 0);

        reg_wr(A_SPEED, 32'hFFFF_FFFF);
        reg_rd(A_SPEED, v);
        chk(v == 32'h0000_007E, "R10 speed field bits", v, 32'h7E);

        // write frame, divider 2
        set_div(2);
        start_txn(32'h5192_BEEF, 16'h0);
        finish_txn(32'h5192_BEEF, 16'h0);
        reg_wr(A_EVENT, 32'h0);
        reg_rd(A_EVENT, v); chk(v[0] == 1'b1, "R7 zero write keeps event", v, 1);
        reg_wr(A_EVENT, 32'h1);
        reg_rd(A_EVENT, v); chk(v == 0, "R7 one clears event", v, 0);

        // read frame, divider 1
        set_div(1);
        start_txn(32'h628A_0000, 16'hA5C3);
        finish_txn(32'h628A_0000, 16'hA5C3);
        reg_wr(A_EVENT, 32'hFFFF_FFFF);
        reg_rd(A_EVENT, v); chk(v == 0, "R7 all ones clears", v, 0);

        // read frame, divider 3, edge bits
        set_div(3);
        start_txn(32'h6FFE_0000, 16'h8001);
        finish_txn(32'h6FFE_0000, 16'h8001);
        reg_wr(A_EVENT, 32'h1);

        // opcode 11 is driven like a write
        set_div(1);
        start_txn(32'h7C12_3456, 16'hFFFF);
        finish_txn(32'h7C12_3456, 16'hFFFF);
        reg_wr(A_EVENT, 32'h1);

        // frame write while busy is ignored
        set_div(2);
        start_txn(32'h50A4_0F0F, 16'h0);
        repeat (100) @(posedge clk);
        reg_wr(A_FRAME, 32'h6000_1234);
        reg_rd(A_FRAME, v); chk(v == 32'h50A4_0F0F, "R8 busy write ignored", v, 32'h50A4_0F0F);
        finish_txn(32'h50A4_0F0F, 16'h0);
        reg_wr(A_EVENT, 32'h1);

        // zero divider blocks
        set_div(0);
        r0 = total_rises;
        reg_wr(A_FRAME, 32'h5000_FFFF);
        repeat (200) @(posedge clk);
        #1 chk(total_rises == r0 && mdc == 1'b0, "R9 no mdc with zero divider", 64'(total_rises), 64'(r0));
        reg_rd(A_EVENT, v); chk(v == 0, "R9 no event with zero divider", v, 0);
        reg_rd(A_FRAME, v); chk(v == 32'h50A4_0F0F, "R9 frame unchanged", v, 32'h50A4_0F0F);

        repeat (20) @(posedge clk);
        chk(q_bits.size() == 0 && seen == pushed, "R2 frame count", 64'(seen), 64'(pushed));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule